// File: doc/BRIEF.md
# Fully Decoded ROM Bus Slave

This block is a read-only slave on a simple shared processor bus. It watches the address lines and a two-bit function code, which a cycle-valid strobe qualifies. It answers only memory reads that land inside a 16-word window at the bottom of the address space. Each word holds a value that counts down from the top: the word at index 0 holds 0x0F, and the word at index 15 holds 0x00.

Decoding runs in two cascaded levels. One level checks the address window. Its result enables the other level, which checks the bus function. A parameter chooses which of the two levels comes first, and the choice has no effect on behaviour. The block responds only to a fully decoded read. It then registers an acknowledge and a data-enable, and it presents the stored word on a data output. When the enable is low, the data output is held at zero, so that several slaves could be OR-combined or turned into real tri-states higher up the chip.

Top module: `romSlaveTop`

## Requirements
- R1: While reset is asserted (rstN low), ack and dataEn are 0 and dataOut is 0.
- R2: A cycle with cycValid high, busFunc 2'b00 (memory read) and busAddr in 0x00..0x0F makes ack and dataEn high after the next rising clock edge.
- R3: During a decoded read, dataOut equals 0x0F minus the address sampled at that edge. Index 0 gives 0x0F and index 15 gives 0x00.
- R4: A cycle whose address is 0x10 or higher leaves ack, dataEn and dataOut at 0, even with function 00 and cycValid high.
- R5: A cycle at a matching address whose busFunc is 2'b01 (memory write), 2'b10 (I/O read) or 2'b11 (I/O write) leaves ack, dataEn and dataOut at 0.
- R6: With cycValid low, no address or function value raises ack or dataEn.
- R7: Whenever dataEn is 0, dataOut is 0. This is the released bus.
- R8: ack and dataEn fall after the first rising edge at which cycValid is sampled low.
- R9: Setting the decode order (parameter ADDR_FIRST) to address-first or to function-first gives identical outputs in every cycle.
- R10: ack and dataEn are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Address bus |
| busFunc | input | 2 | Bus function: 00 mem read, 01 mem write, 10 I/O read, 11 I/O write |
| cycValid | input | 1 | Strobe that qualifies address and function |
| dataOut | output | 8 | Read data, zero while released |
| dataEn | output | 1 | Data drive enable for the shared bus |
| ack | output | 1 | Acknowledge to the bus master |

## Verification
Every result of this block is due exactly one rising edge after the cycle that causes it. This applies to ack, dataEn and dataOut alike, because each passes through a single register stage. The driver applies one bus cycle per clock on the falling edge and queues the expected outputs for that cycle. The monitor samples one time unit after each following rising edge and compares against the head of the queue. The driver pushes exactly one item per clock, so each comparison lines up with the edge that registered that stimulus. A second instance, built with the other decode order, is compared against the first at the same sampling points.

// File: rtl/romSlavePkg.sv
package romSlavePkg;

  // Bus function codes
  typedef enum logic [1:0] {
    FN_MEM_RD = 2'b00,
    FN_MEM_WR = 2'b01,
    FN_IO_RD  = 2'b10,
    FN_IO_WR  = 2'b11
  } busFunc_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // load the addressed word this edge
    logic drive;    // present the held word on dataOut
  } ctrlStrobe_t;

endpackage

// File: rtl/romSlaveDecode.sv
module romSlaveDecode #(
  parameter int ADDR_W     = 8,
  parameter int IDX_W      = 4,
  parameter int BASE_ADDR  = 0,
  parameter bit ADDR_FIRST = 1'b1
) (
  input  logic              cycValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busFunc,
  output logic              fullHit
);
  import romSlavePkg::*;

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [ADDR_W-1:0] BASE_VEC = ADDR_W'(BASE_ADDR);
  localparam logic [TAG_W-1:0]  BASE_TAG = BASE_VEC[ADDR_W-1:IDX_W];

  logic addrOk;
  logic funcOk;
  logic firstLvl;

  assign addrOk = (busAddr[ADDR_W-1:IDX_W] == BASE_TAG);
  assign funcOk = (busFunc == FN_MEM_RD);

  // Level one is qualified by the strobe and enables level two
  generate
    if (ADDR_FIRST) begin : gAddrFirst
      assign firstLvl = cycValid & addrOk;
      assign fullHit  = firstLvl & funcOk;
    end else begin : gFuncFirst
      assign firstLvl = cycValid & funcOk;
      assign fullHit  = firstLvl & addrOk;
    end
  endgenerate

endmodule

// File: rtl/romSlaveCtrl.sv
module romSlaveCtrl #(
  parameter int ADDR_W     = 8,
  parameter int IDX_W      = 4,
  parameter int BASE_ADDR  = 0,
  parameter bit ADDR_FIRST = 1'b1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cycValid,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [1:0]                busFunc,
  output romSlavePkg::ctrlStrobe_t  strobe,
  output logic                      ack
);

  logic fullHit;
  logic ackQ;

  romSlaveDecode #(
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .BASE_ADDR (BASE_ADDR),
    .ADDR_FIRST(ADDR_FIRST)
  ) uDecode (
    .cycValid(cycValid),
    .busAddr (busAddr),
    .busFunc (busFunc),
    .fullHit (fullHit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= fullHit;
  end

  always_comb begin
    strobe.capture = fullHit;
    strobe.drive   = ackQ;
  end

  assign ack = ackQ;

endmodule

// File: rtl/romSlaveData.sv
module romSlaveData #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [IDX_W-1:0]          wordIdx,
  input  romSlavePkg::ctrlStrobe_t  strobe,
  output logic [DATA_W-1:0]         dataOut,
  output logic                      dataEn
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] romWord [DEPTH];
  logic [DATA_W-1:0] dataQ;

  // Contents count downward from DEPTH-1 at index 0
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : gRom
      assign romWord[i] = DATA_W'(DEPTH - 1 - i);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)              dataQ <= '0;
    else if (strobe.capture) dataQ <= romWord[wordIdx];
  end

  assign dataEn  = strobe.drive;
  assign dataOut = strobe.drive ? dataQ : '0;

endmodule

// File: rtl/romSlaveTop.sv
module romSlaveTop #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 4,
  parameter int BASE_ADDR  = 0,
  parameter bit ADDR_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busFunc,
  input  logic              cycValid,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataEn,
  output logic              ack
);
  import romSlavePkg::*;

  ctrlStrobe_t strobe;

  romSlaveCtrl #(
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .BASE_ADDR (BASE_ADDR),
    .ADDR_FIRST(ADDR_FIRST)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cycValid(cycValid),
    .busAddr (busAddr),
    .busFunc (busFunc),
    .strobe  (strobe),
    .ack     (ack)
  );

  romSlaveData #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .wordIdx(busAddr[IDX_W-1:0]),
    .strobe (strobe),
    .dataOut(dataOut),
    .dataEn (dataEn)
  );

endmodule

// File: rtl/romSlaveChk.sv
module romSlaveChk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 4,
  parameter int BASE_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busFunc,
  input logic              cycValid,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataEn,
  input logic              ack
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE_ADDR + DEPTH - 1);

  logic inWin;
  assign inWin = (busAddr >= LO) && (busAddr <= HI);

  // R10
  ack_en_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack == dataEn);

  // R7
  bus_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataEn |-> dataOut == '0);

  // R2
  read_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && busFunc == 2'b00 && inWin) |=> ack);

  // R3
  read_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && busFunc == 2'b00 && inWin) |=>
      dataOut == DATA_W'(DEPTH - 1 - int'($past(busAddr) - LO)));

  // R4
  out_of_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |=> !ack);

  // R5
  wrong_func_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busFunc != 2'b00) |=> !ack);

  // R6
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cycValid |=> !dataEn);

endmodule

bind romSlaveTop romSlaveChk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .IDX_W    (IDX_W),
  .BASE_ADDR(BASE_ADDR)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busFunc (busFunc),
  .cycValid(cycValid),
  .dataOut (dataOut),
  .dataEn  (dataEn),
  .ack     (ack)
);

// File: tb/sim_romSlaveTop.sv
module sim_romSlaveTop;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  typedef struct {
    logic       ack;
    logic [7:0] data;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic [1:0] busFunc = '0;
  logic       cycValid = 1'b0;
  logic [7:0] dataOut0, dataOut1;
  logic       dataEn0, dataEn1, ack0, ack1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  romSlaveTop #(.ADDR_FIRST(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busFunc(busFunc),
    .cycValid(cycValid), .dataOut(dataOut0), .dataEn(dataEn0), .ack(ack0)
  );

  romSlaveTop #(.ADDR_FIRST(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busFunc(busFunc),
    .cycValid(cycValid), .dataOut(dataOut1), .dataEn(dataEn1), .ack(ack1)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: one bus cycle per clock, expected result queued
  task automatic busCycle(input logic v, input logic [1:0] fn, input logic [7:0] a, input string tag);
    expItem_t it;
    @(negedge clk);
    cycValid = v;
    busFunc  = fn;
    busAddr  = a;
    it.ack  = v && (fn == 2'b00) && (a < 8'h10);
    it.data = it.ack ? (8'h0F - a) : 8'h00;
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare one edge after each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check({it.tag, " ack"},    {7'b0, ack0},    {7'b0, it.ack});
        check({it.tag, " dataEn"}, {7'b0, dataEn0}, {7'b0, it.ack});
        check({it.tag, " dataOut R7"}, dataOut0, it.data);
        // R9: other decode order matches
        check("R9 order ack",  {6'b0, ack1, dataEn1}, {6'b0, ack0, dataEn0});
        check("R9 order data", dataOut1, dataOut0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with a read pending on the bus
    cycValid = 1'b1;
    busFunc  = 2'b00;
    busAddr  = 8'h03;
    repeat (3) @(posedge clk);
    #1;
    check("R1 ack", {7'b0, ack0}, 8'h00);
    check("R1 dataEn", {7'b0, dataEn0}, 8'h00);
    check("R1 dataOut", dataOut0, 8'h00);
    @(negedge clk);
    cycValid = 1'b0;
    rstN = 1'b1;

    // R2 R3: every word, back to back
    for (int i = 0; i < 16; i++) busCycle(1'b1, 2'b00, 8'(i), "R2 R3 read");
    // R8: strobe falls after a read
    busCycle(1'b0, 2'b00, 8'h0F, "R8 strobe low");
    busCycle(1'b1, 2'b00, 8'h07, "R3 read");
    busCycle(1'b0, 2'b00, 8'h07, "R8 strobe low");
    // R4: outside the window
    busCycle(1'b1, 2'b00, 8'h10, "R4 addr 0x10");
    busCycle(1'b1, 2'b00, 8'hFF, "R4 addr 0xFF");
    busCycle(1'b1, 2'b00, 8'h8F, "R4 addr 0x8F");
    busCycle(1'b1, 2'b00, 8'h00, "R2 after miss");
    busCycle(1'b1, 2'b00, 8'h20, "R4 addr 0x20 after hit");
    // R5: wrong functions at a matching address
    busCycle(1'b1, 2'b01, 8'h05, "R5 mem write");
    busCycle(1'b1, 2'b10, 8'h05, "R5 io read");
    busCycle(1'b1, 2'b11, 8'h05, "R5 io write");
    busCycle(1'b1, 2'b00, 8'h05, "R3 read");
    busCycle(1'b1, 2'b11, 8'h0A, "R5 io write after hit");
    // R6: no strobe
    for (int i = 0; i < 4; i++) busCycle(1'b0, 2'(i), 8'(i * 3), "R6 no strobe");
    busCycle(1'b1, 2'b00, 8'h0E, "R3 read");
    busCycle(1'b0, 2'b00, 8'h0E, "R8 strobe low");
    busCycle(1'b0, 2'b00, 8'h00, "R7 idle");
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule